// File: doc/BRIEF.md
# Readout Event Packet Builder

This block gathers per-event readout words from four upstream processing sources. Each source feeds two streams, and each stream lands in a shallow FIFO that exists only to absorb flow-control slack. The block turns those words into framed output packets. Each packet opens with a tagged header word, carries the payload, and closes with a word-count word and a CRC word. Trigger and timing details for each event (packet kind and a 24-bit event number) come from a small side queue, which the timing-interface logic fills.

Two packet kinds exist, and the timing entry selects one per event:

- **Trigger-object events** merge every stream of every source into one packet.
- **Input-data events** give each source its own packet, in ascending source order.

A control state machine halts output while the downstream link holds its stop line. It raises a per-stream stall toward the sources when a FIFO nears capacity. It raises BUSY when buffering is effectively exhausted.

Top module: `readout_pkt_builder`

## Requirements
- R1: A header word is `{4'hA, kind, src[2:0], event_id[23:0]}`. `kind` is 0 for trigger objects and 1 for input data. `src` is 3'h7 for merged packets and the source index for split packets.
- R2: For a kind-0 event, exactly one packet is produced. Its payload is streams 0 to 7 in ascending order, and each stream's words appear in arrival order up to and including the word flagged last.
- R3: For a kind-1 event, one packet is produced per source, sources in ascending order. The packet for source k carries stream 2k followed by stream 2k+1.
- R4: After the payload come two words. The first is `{4'hE, 12'h000, payload_word_count[15:0]}`. The second is the CRC word.
- R5: The CRC word is CRC-32 with polynomial 0x04C11DB7 and initial value 0xFFFFFFFF. It is computed MSB first, without bit reflection or final inversion, one 32-bit word at a time, over the header and all payload words.
- R6: `out_sop` marks only the header word. `out_eop` marks only the CRC word.
- R7: While `ds_stop` is high, `out_valid` is low and no word is consumed.
- R8: `up_stall[i]` is high exactly while stream i's FIFO holds at least `AFULL_LVL` words.
- R9: `busy` is high while any stream FIFO holds at least `BUSY_LVL` words, or while the timing queue is empty and some stream FIFO is full.
- R10: A word offered to a full stream FIFO is discarded and never appears in any packet.
- R11: No packet starts while the timing queue is empty. An event's timing entry is retired only after its last packet's CRC word.
- R12: After reset, `out_valid`, `busy` and every `up_stall` bit are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | N_SRC*SPS | Per-stream word strobe |
| in_last | input | N_SRC*SPS | Per-stream end-of-event flag |
| in_data | input | N_SRC*SPS*32 | Per-stream word; stream i occupies bits 32i+31 down to 32i |
| up_stall | output | N_SRC*SPS | Per-stream backpressure toward the sources |
| tt_valid | input | 1 | Push a timing entry |
| tt_kind | input | 1 | Packet kind of the entry (0 merged, 1 split) |
| tt_evid | input | 24 | Event number of the entry |
| ds_stop | input | 1 | Downstream backpressure |
| out_valid | output | 1 | Output word present and accepted this cycle |
| out_data | output | 32 | Output word |
| out_sop | output | 1 | Header word marker |
| out_eop | output | 1 | CRC word marker |
| busy | output | 1 | Buffering exhausted |

## Verification
The bench builds the block with a stream FIFO depth of 4, a stall level of 3, a BUSY level of 4 and a timing queue depth of 2. With these values a handful of pushes on one stream reaches the stall threshold, then a full FIFO, then BUSY, and a fifth word probes the discard path. Events of one to four words per stream cover both packet kinds, with and without a toggling downstream stop in the middle of a packet. A stall held before the timing entry arrives shows that nothing leaks out early.

// File: rtl/rb_pkg.sv
package rb_pkg;

    localparam int WORD_W = 32;
    localparam int EVID_W = 24;
    localparam logic [3:0]  HDR_MARK = 4'hA;
    localparam logic [3:0]  TRL_MARK = 4'hE;
    localparam logic [2:0]  MERGED_SRC = 3'h7;
    localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
    localparam logic [31:0] CRC_SEED = 32'hFFFFFFFF;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HDR,
        PH_PAY,
        PH_CNT,
        PH_CRC
    } phase_t;

    typedef struct packed {
        logic              last;
        logic [WORD_W-1:0] data;
    } beat_t;

    typedef struct packed {
        logic              kind;
        logic [EVID_W-1:0] evid;
    } tt_t;

    // Fold one word into the running checksum, most significant bit first.
    function automatic logic [31:0] crc_fold(input logic [31:0] acc, input logic [31:0] w);
        logic [31:0] r;
        logic        fb;
        r = acc;
        for (int i = 31; i >= 0; i--) begin
            fb = r[31] ^ w[i];
            r  = {r[30:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

endpackage

// File: rtl/rb_fifo.sv
module rb_fifo #(
    parameter int W     = 33,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] level
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          wr_en, rd_en;

    assign empty = (level == '0);
    assign full  = (level == CW'(DEPTH));
    assign wr_en = push && !full;
    assign rd_en = pop && !empty;
    assign dout  = mem[rp];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (wr_en) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (rd_en) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            case ({wr_en, rd_en})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/rb_ctrl.sv
module rb_ctrl
    import rb_pkg::*;
#(
    parameter int N_SRC = 4,
    parameter int SPS   = 2,
    localparam int N_STR  = N_SRC * SPS,
    localparam int SRC_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int SUB_W  = (SPS > 1) ? $clog2(SPS) : 1,
    localparam int STRM_W = (N_STR > 1) ? $clog2(N_STR) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tq_empty,
    input  tt_t                     tq_head,
    input  logic [N_STR-1:0]        f_empty,
    input  beat_t [N_STR-1:0]       f_head,
    input  logic                    ds_stop,
    output logic [N_STR-1:0]        f_pop,
    output logic                    tq_pop,
    output logic                    out_valid,
    output logic [WORD_W-1:0]       out_data,
    output logic                    out_sop,
    output logic                    out_eop
);

    localparam logic [SRC_W-1:0] SRC_LAST = SRC_W'(N_SRC - 1);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SPS - 1);

    phase_t            ph;
    logic [SRC_W-1:0]  src;
    logic [SUB_W-1:0]  sub;
    logic [15:0]       wcnt;
    logic [31:0]       crc;

    logic [STRM_W-1:0] strm;
    beat_t             cur;
    logic              cur_empty;
    logic              grp_done;
    logic              more_src;
    logic [31:0]       hdr_word;

    always_comb begin
        strm      = STRM_W'(int'(src) * SPS + int'(sub));
        cur       = f_head[strm];
        cur_empty = f_empty[strm];
        grp_done  = (sub == SUB_LAST) && (tq_head.kind || src == SRC_LAST);
        more_src  = tq_head.kind && (src != SRC_LAST);
        hdr_word  = {HDR_MARK, tq_head.kind,
                     tq_head.kind ? 3'(src) : MERGED_SRC, tq_head.evid};

        out_valid = 1'b0;
        out_data  = '0;
        out_sop   = 1'b0;
        out_eop   = 1'b0;
        f_pop     = '0;
        tq_pop    = 1'b0;
        case (ph)
            PH_HDR: begin
                out_valid = !ds_stop;
                out_data  = hdr_word;
                out_sop   = 1'b1;
            end
            PH_PAY: begin
                out_valid   = !ds_stop && !cur_empty;
                out_data    = cur.data;
                f_pop[strm] = out_valid;
            end
            PH_CNT: begin
                out_valid = !ds_stop;
                out_data  = {TRL_MARK, 12'h000, wcnt};
            end
            PH_CRC: begin
                out_valid = !ds_stop;
                out_data  = crc;
                out_eop   = 1'b1;
                tq_pop    = out_valid && !more_src;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= PH_IDLE;
            src  <= '0;
            sub  <= '0;
            wcnt <= '0;
            crc  <= CRC_SEED;
        end else begin
            case (ph)
                PH_IDLE: begin
                    src <= '0;
                    sub <= '0;
                    if (!tq_empty) ph <= PH_HDR;
                end
                PH_HDR: if (out_valid) begin
                    crc  <= crc_fold(CRC_SEED, hdr_word);
                    wcnt <= '0;
                    ph   <= PH_PAY;
                end
                PH_PAY: if (out_valid) begin
                    crc  <= crc_fold(crc, cur.data);
                    wcnt <= wcnt + 16'd1;
                    if (cur.last) begin
                        if (grp_done) begin
                            ph <= PH_CNT;
                        end else if (sub == SUB_LAST) begin
                            sub <= '0;
                            src <= src + 1'b1;
                        end else begin
                            sub <= sub + 1'b1;
                        end
                    end
                end
                PH_CNT: if (out_valid) ph <= PH_CRC;
                PH_CRC: if (out_valid) begin
                    sub <= '0;
                    if (more_src) begin
                        src <= src + 1'b1;
                        ph  <= PH_HDR;
                    end else begin
                        src <= '0;
                        ph  <= PH_IDLE;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/readout_pkt_builder.sv
module readout_pkt_builder
    import rb_pkg::*;
#(
    parameter int N_SRC      = 4,
    parameter int SPS        = 2,
    parameter int FIFO_DEPTH = 8,
    parameter int AFULL_LVL  = 6,
    parameter int BUSY_LVL   = 8,
    parameter int TQ_DEPTH   = 4,
    localparam int N_STR     = N_SRC * SPS,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1),
    localparam int TQ_LVL_W  = $clog2(TQ_DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_STR-1:0]          in_valid,
    input  logic [N_STR-1:0]          in_last,
    input  logic [N_STR*WORD_W-1:0]   in_data,
    output logic [N_STR-1:0]          up_stall,
    input  logic                      tt_valid,
    input  logic                      tt_kind,
    input  logic [EVID_W-1:0]         tt_evid,
    input  logic                      ds_stop,
    output logic                      out_valid,
    output logic [WORD_W-1:0]         out_data,
    output logic                      out_sop,
    output logic                      out_eop,
    output logic                      busy
);

    beat_t [N_STR-1:0]  f_head;
    logic  [N_STR-1:0]  f_empty, f_full, f_pop, over_busy;
    logic  [LVL_W-1:0]  f_lvl [N_STR];

    tt_t                 tq_head, tq_din;
    logic                tq_empty, tq_full, tq_pop;
    logic [TQ_LVL_W-1:0] tq_lvl;

    for (genvar g = 0; g < N_STR; g++) begin : g_strm
        beat_t din;
        assign din = '{last: in_last[g], data: in_data[g*WORD_W +: WORD_W]};

        rb_fifo #(.W($bits(beat_t)), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk   (clk),
            .rst   (rst),
            .push  (in_valid[g]),
            .din   (din),
            .pop   (f_pop[g]),
            .dout  (f_head[g]),
            .empty (f_empty[g]),
            .full  (f_full[g]),
            .level (f_lvl[g])
        );

        assign up_stall[g]  = (f_lvl[g] >= LVL_W'(AFULL_LVL));
        assign over_busy[g] = (f_lvl[g] >= LVL_W'(BUSY_LVL));
    end

    assign tq_din = '{kind: tt_kind, evid: tt_evid};

    rb_fifo #(.W($bits(tt_t)), .DEPTH(TQ_DEPTH)) u_tq (
        .clk   (clk),
        .rst   (rst),
        .push  (tt_valid),
        .din   (tq_din),
        .pop   (tq_pop),
        .dout  (tq_head),
        .empty (tq_empty),
        .full  (tq_full),
        .level (tq_lvl)
    );

    assign busy = (|over_busy) || (tq_empty && (|f_full));

    rb_ctrl #(.N_SRC(N_SRC), .SPS(SPS)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .tq_empty  (tq_empty),
        .tq_head   (tq_head),
        .f_empty   (f_empty),
        .f_head    (f_head),
        .ds_stop   (ds_stop),
        .f_pop     (f_pop),
        .tq_pop    (tq_pop),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_sop   (out_sop),
        .out_eop   (out_eop)
    );

endmodule

// File: rtl/rb_checker.sv
module rb_checker #(
    parameter int N_STR = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             ds_stop,
    input logic             out_valid,
    input logic             out_sop,
    input logic             out_eop,
    input logic [31:0]      out_data,
    input logic [N_STR-1:0] in_valid,
    input logic [N_STR-1:0] up_stall,
    input logic             tq_empty
);

    assert_stop_holds_R7: assert property (@(posedge clk) disable iff (rst)
        ds_stop |-> !out_valid);

    assert_hdr_mark_R1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sop) |-> (out_data[31:28] == 4'hA));

    assert_start_needs_entry_R11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sop) |-> !tq_empty);

    assert_frame_marks_R6: assert property (@(posedge clk) disable iff (rst)
        out_eop |-> !out_sop);

    for (genvar g = 0; g < N_STR; g++) begin : g_chk
        assert_stall_cause_R8: assert property (@(posedge clk) disable iff (rst)
            $rose(up_stall[g]) |-> $past(in_valid[g]));
    end

endmodule

bind readout_pkt_builder rb_checker #(.N_STR(N_STR)) u_rb_checker (
    .clk       (clk),
    .rst       (rst),
    .ds_stop   (ds_stop),
    .out_valid (out_valid),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_data  (out_data),
    .in_valid  (in_valid),
    .up_stall  (up_stall),
    .tq_empty  (tq_empty)
);

// File: tb/sim_readout_pkt_builder.sv
module sim_readout_pkt_builder;

    localparam int NS   = 4;
    localparam int SP   = 2;
    localparam int NSTR = NS * SP;
    localparam int MAXW = 128;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NSTR-1:0]   in_valid = '0;
    logic [NSTR-1:0]   in_last = '0;
    logic [NSTR*32-1:0] in_data = '0;
    logic [NSTR-1:0]   up_stall;
    logic              tt_valid = 1'b0;
    logic              tt_kind = 1'b0;
    logic [23:0]       tt_evid = '0;
    logic              ds_stop = 1'b0;
    logic              out_valid, out_sop, out_eop, busy;
    logic [31:0]       out_data;

    always #4 clk = ~clk;

    readout_pkt_builder #(
        .N_SRC(NS), .SPS(SP), .FIFO_DEPTH(4), .AFULL_LVL(3), .BUSY_LVL(4), .TQ_DEPTH(2)
    ) u0 (.*);

    int checks = 0;
    int errors = 0;

    // {kind, stall, evid[23:0], len[3:0], expected word total[7:0]}
    localparam logic [37:0] VEC [4] = '{
        {1'b0, 1'b0, 24'h000101, 4'd1, 8'd11},
        {1'b1, 1'b0, 24'hABCDEF, 4'd2, 8'd28},
        {1'b0, 1'b1, 24'h7FFFFF, 4'd3, 8'd27},
        {1'b1, 1'b1, 24'h000004, 4'd4, 8'd44}
    };

    logic [31:0] cap_d [MAXW];
    logic        cap_s [MAXW];
    logic        cap_e [MAXW];
    int          ncap = 0;
    int          neop = 0;
    logic [31:0] exp_d [MAXW];
    string       exp_t [MAXW];
    int          nexp;
    int          lens [NSTR];
    int          cyc = 0;

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (ncap < MAXW) begin
                cap_d[ncap] = out_data;
                cap_s[ncap] = out_sop;
                cap_e[ncap] = out_eop;
            end
            ncap++;
            if (out_eop) neop++;
        end
        if (!rst && ds_stop && out_valid) begin
            errors++;
            $display("FAIL R7 out_valid=1 while ds_stop=1 expected 0");
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired cycles=%0d expected below 150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [31:0] pat(input logic [23:0] ev, input int s, input int j);
        return {ev[7:0], 8'(s), 16'(j)};
    endfunction

    function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [31:0] w);
        logic [31:0] r = c;
        for (int b = 0; b < 32; b++) begin
            logic top = r[31] ^ w[31-b];
            r = r << 1;
            r = top ? (r ^ 32'h04C11DB7) : r;
        end
        return r;
    endfunction

    task automatic add_exp(input logic [31:0] w, input string t);
        exp_d[nexp] = w;
        exp_t[nexp] = t;
        nexp++;
    endtask

    task automatic build_exp(input logic kind, input logic [23:0] ev);
        nexp = 0;
        for (int p = 0; p < (kind ? NS : 1); p++) begin
            logic [31:0] c;
            int n = 0;
            logic [31:0] h = {4'hA, kind, kind ? 3'(p) : 3'h7, ev};
            add_exp(h, "R1");
            c = ref_crc(32'hFFFFFFFF, h);
            for (int s = (kind ? p * SP : 0); s < (kind ? p * SP + SP : NSTR); s++) begin
                for (int j = 0; j < lens[s]; j++) begin
                    add_exp(pat(ev, s, j), kind ? "R3" : "R2");
                    c = ref_crc(c, pat(ev, s, j));
                    n++;
                end
            end
            add_exp({4'hE, 12'h000, 16'(n)}, "R4");
            add_exp(c, "R5");
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        check(ncap == nexp, "R2/R3 word total", 32'(ncap), 32'(nexp));
        for (int i = 0; i < nexp && i < ncap; i++) begin
            bool_check(i);
        end
    endtask

    task automatic bool_check(input int i);
        logic es = (exp_t[i] == "R1");
        logic ee = (exp_t[i] == "R5");
        check(cap_d[i] == exp_d[i], exp_t[i], cap_d[i], exp_d[i]);
        check(cap_s[i] == es && cap_e[i] == ee, "R6 sop/eop",
              {30'd0, cap_s[i], cap_e[i]}, {30'd0, es, ee});
    endtask

    task automatic wait_eop(input int n);
        for (int k = 0; k < 3000 && neop < n; k++) step();
        ds_stop = 1'b0;
        step();
        step();
    endtask

    task automatic push_tt(input logic kind, input logic [23:0] ev);
        tt_valid = 1'b1;
        tt_kind  = kind;
        tt_evid  = ev;
        step();
        tt_valid = 1'b0;
    endtask

    initial begin
        step();
        step();
        rst = 1'b0;
        #3;
        // R12: idle state after reset
        check(out_valid == 1'b0 && busy == 1'b0 && up_stall == '0, "R12 reset outputs",
              {30'd0, out_valid, busy}, 32'd0);

        // Table walk
        for (int v = 0; v < 4; v++) begin
            logic        kind  = VEC[v][37];
            logic        stall = VEC[v][36];
            logic [23:0] ev    = VEC[v][35:12];
            int          len   = int'(VEC[v][11:8]);
            int          tot   = int'(VEC[v][7:0]);
            ncap = 0;
            neop = 0;
            for (int s = 0; s < NSTR; s++) lens[s] = len;
            for (int j = 0; j < len; j++) begin
                step();
                in_valid = '1;
                for (int s = 0; s < NSTR; s++) begin
                    in_data[s*32 +: 32] = pat(ev, s, j);
                    in_last[s] = (j == len - 1);
                end
            end
            step();
            in_valid = '0;
            in_last  = '0;
            step();
            step();
            // R11: data waiting, no timing entry yet
            check(ncap == 0, "R11 no start without entry", 32'(ncap), 32'd0);
            push_tt(kind, ev);
            for (int k = 0; k < 3000 && neop < (kind ? NS : 1); k++) begin
                ds_stop = stall && (k % 3 == 1);
                step();
            end
            wait_eop(kind ? NS : 1);
            build_exp(kind, ev);
            check(ncap == tot, kind ? "R3 table total" : "R2 table total", 32'(ncap), 32'(tot));
            compare_all();
            check(busy == 1'b0 && up_stall == '0, "R9 drained", {31'd0, busy}, 32'd0);
        end

        // Directed: stall levels, busy, full discard, ds_stop hold
        ncap = 0;
        neop = 0;
        ds_stop = 1'b1;
        for (int j = 0; j < 2; j++) begin
            step();
            in_valid = 8'h01;
            in_data[31:0] = pat(24'h123456, 0, j);
            in_last[0] = 1'b0;
        end
        step();
        in_valid = '0;
        step();
        check(up_stall[0] == 1'b0, "R8 below level", {31'd0, up_stall[0]}, 32'd0);
        in_valid = 8'h01;
        in_data[31:0] = pat(24'h123456, 0, 2);
        step();
        in_valid = '0;
        step();
        check(up_stall[0] == 1'b1, "R8 at level", {31'd0, up_stall[0]}, 32'd1);
        check(busy == 1'b0, "R9 not yet busy", {31'd0, busy}, 32'd0);
        in_valid = 8'h01;
        in_data[31:0] = pat(24'h123456, 0, 3);
        in_last[0] = 1'b1;
        step();
        in_data[31:0] = 32'hDEADBEEF;
        in_last[0] = 1'b0;
        step();
        in_valid = '0;
        step();
        check(busy == 1'b1, "R9 full buffer", {31'd0, busy}, 32'd1);
        push_tt(1'b0, 24'h123456);
        for (int k = 0; k < 5; k++) step();
        check(ncap == 0, "R7 held by ds_stop", 32'(ncap), 32'd0);
        check(busy == 1'b1, "R9 level busy with entry", {31'd0, busy}, 32'd1);
        in_valid = 8'hFE;
        in_last  = 8'hFE;
        for (int s = 1; s < NSTR; s++) in_data[s*32 +: 32] = pat(24'h123456, s, 0);
        step();
        in_valid = '0;
        in_last  = '0;
        ds_stop  = 1'b0;
        wait_eop(1);
        lens[0] = 4;
        for (int s = 1; s < NSTR; s++) lens[s] = 1;
        build_exp(1'b0, 24'h123456);
        // R10: the discarded word must not appear
        compare_all();
        check(up_stall == '0 && busy == 1'b0, "R8 released", {24'd0, up_stall}, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule